// File: doc/BRIEF.md
# Phase-Scheduled Wireless Access Controller

This block decides which group of directional wireless transceivers may use a shared frequency band on a given clock cycle. The transceivers are grouped into four orientation modes: horizontal, vertical, and two diagonals. Only one mode owns the band at a time, so every link in that mode transmits in the same cycles. Links in different modes take turns.

Each mode's turn (its phase) is split into two equal half-duplex sub-phases, one for each direction of the link pair. The controller drives one wake line for every mode and direction pair. It also drives the current mode and sub-phase indices, which the attached wireless ports use to gate flit launch.

A last-cycle flag marks the final cycle of every sub-phase. A room flag tells a sender whether enough cycles remain in the sub-phase to fit a whole flit of `FLIT_CYC` cycles. The phase length is programmable. A new value is taken only when the full four-mode rotation wraps back to horizontal.

Top module: `phase_sched_ctrl`

## Requirements
- R1: After reset the block is in mode horizontal (mode_o = 0), sub-phase 0, at the first cycle of that sub-phase.
- R2: Modes follow the fixed order horizontal (0), vertical (1), first diagonal (2), second diagonal (3), and then wrap back to horizontal. The mode changes only after the last cycle of sub-phase 1.
- R3: Each phase has sub-phase 0 followed by sub-phase 1. Each sub-phase lasts half of the active phase length, in clock cycles.
- R4: wake_o is one-hot on every cycle. The set bit is at index mode_o*2 + sub_o.
- R5: After reset the active phase length is DEF_LEN (20 by default), so each sub-phase lasts 10 cycles.
- R6: A programmed length that is odd or less than 2 is used as 2, which gives one-cycle sub-phases.
- R7: phase_len_i is sampled only on the last cycle of sub-phase 1 of mode 3. It takes effect from the next cycle. Changes at any other time have no effect on the current rotation.
- R8: last_o is high exactly on the final cycle of each sub-phase.
- R9: room_o is high when the cycles left in the sub-phase, counting the current cycle, are at least FLIT_CYC (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phase_len_i | input | LEN_W | Requested phase length, both directions together |
| wake_o | output | 2*NUM_MODES | One-hot transceiver wake, index mode*2+direction |
| mode_o | output | 2 | Active mode index |
| sub_o | output | 1 | Active sub-phase (direction) |
| last_o | output | 1 | Final cycle of the sub-phase |
| room_o | output | 1 | A full flit still fits in the sub-phase |

## Verification
Every output is a direct decode of registered state. A result therefore shows on the first cycle after the clock edge that moves the counter, and a new length shows one cycle after the sampling edge at the end of a rotation.

The bench keeps a cycle model built from the requirements. Each falling edge, it pushes the model's expected outputs into a queue and then steps the model using the length on the pins at the coming rising edge. A monitor pops each entry shortly after that falling edge and compares all outputs, so every expectation lines up with exactly one cycle of the design.

// File: rtl/phase_sched_pkg.sv
package phase_sched_pkg;
  localparam int NUM_MODES = 4;
  localparam int MODE_W    = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_H  = 2'd0,
    MODE_V  = 2'd1,
    MODE_D1 = 2'd2,
    MODE_D2 = 2'd3
  } mode_e;
endpackage

// File: rtl/phase_len_reg.sv
module phase_len_reg #(
  parameter int LEN_W   = 8,
  parameter int DEF_LEN = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] half_o
);
  localparam logic [LEN_W-1:0] DefHalf = LEN_W'(DEF_LEN / 2);

  logic [LEN_W-1:0] half_d;

  // odd or too short lengths collapse to 2
  always_comb begin
    if (len_i < LEN_W'(2) || len_i[0]) half_d = LEN_W'(1);
    else                               half_d = len_i >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     half_o <= DefHalf;
    else if (load_i) half_o <= half_d;
  end
endmodule

// File: rtl/phase_timer.sv
module phase_timer
  import phase_sched_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int FLIT_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LEN_W-1:0] half_i,
  output mode_e            mode_o,
  output logic             sub_o,
  output logic             last_o,
  output logic             room_o,
  output logic             wrap_o
);
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] left;

  assign last_o = (cnt_q == half_i - LEN_W'(1));
  assign left   = half_i - cnt_q;
  assign room_o = (left >= LEN_W'(FLIT_CYC));
  assign wrap_o = last_o && sub_o && (mode_o == MODE_D2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sub_o  <= 1'b0;
      mode_o <= MODE_H;
    end else if (last_o) begin
      cnt_q <= '0;
      sub_o <= ~sub_o;
      if (sub_o) mode_o <= mode_e'(mode_o + 2'd1);
    end else begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end
endmodule

// File: rtl/wake_decode.sv
module wake_decode
  import phase_sched_pkg::*;
#(
  parameter int N_MODES = NUM_MODES
) (
  input  mode_e                  mode_i,
  input  logic                   sub_i,
  output logic [2*N_MODES-1:0]   wake_o
);
  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    for (genvar d = 0; d < 2; d++) begin : g_dir
      assign wake_o[m*2+d] = (int'(mode_i) == m) && (int'(sub_i) == d);
    end
  end
endmodule

// File: rtl/phase_sched_ctrl.sv
module phase_sched_ctrl
  import phase_sched_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int DEF_LEN  = 20,
  parameter int FLIT_CYC = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [LEN_W-1:0]       phase_len_i,
  output logic [2*NUM_MODES-1:0] wake_o,
  output logic [MODE_W-1:0]      mode_o,
  output logic                   sub_o,
  output logic                   last_o,
  output logic                   room_o
);
  logic [LEN_W-1:0] half;
  logic             wrap;
  mode_e            mode;

  phase_len_reg #(.LEN_W(LEN_W), .DEF_LEN(DEF_LEN)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wrap),
    .len_i  (phase_len_i),
    .half_o (half)
  );

  phase_timer #(.LEN_W(LEN_W), .FLIT_CYC(FLIT_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (half),
    .mode_o (mode),
    .sub_o  (sub_o),
    .last_o (last_o),
    .room_o (room_o),
    .wrap_o (wrap)
  );

  wake_decode #(.N_MODES(NUM_MODES)) u_wake (
    .mode_i (mode),
    .sub_i  (sub_o),
    .wake_o (wake_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/phase_sched_ctrl_chk.sv
module phase_sched_ctrl_chk #(
  parameter int N_WAKE   = 8,
  parameter int FLIT_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_WAKE-1:0] wake_o,
  input logic [1:0]        mode_o,
  input logic              sub_o,
  input logic              last_o,
  input logic              room_o
);
  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(wake_o) == 1);

  p_wake_map_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o[{mode_o, sub_o}]);

  p_order_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && sub_o) |=> (mode_o == $past(mode_o) + 2'd1));

  p_sub_flip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (sub_o != $past(sub_o)));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_o |=> ($stable(mode_o) && $stable(sub_o)));

  p_last_room_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (room_o == (FLIT_CYC <= 1)));
endmodule

bind phase_sched_ctrl phase_sched_ctrl_chk #(
  .N_WAKE   (2*phase_sched_pkg::NUM_MODES),
  .FLIT_CYC (FLIT_CYC)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wake_o (wake_o),
  .mode_o (mode_o),
  .sub_o  (sub_o),
  .last_o (last_o),
  .room_o (room_o)
);

// File: tb/phase_sched_ctrl_test.sv
`timescale 1ns/1ps
module phase_sched_ctrl_test;
  localparam int LEN_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LEN_W-1:0] phase_len_i = 8'd20;
  logic [7:0]       wake_o;
  logic [1:0]       mode_o;
  logic             sub_o, last_o, room_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // expected item: {wake, mode, sub, last, room}
  logic [12:0] q_exp[$];
  string       q_tag[$];

  int m_mode = 0, m_sub = 0, m_cnt = 0, m_half = 10;

  always #2.5 clk_i = ~clk_i;

  phase_sched_ctrl uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .phase_len_i (phase_len_i),
    .wake_o      (wake_o),
    .mode_o      (mode_o),
    .sub_o       (sub_o),
    .last_o      (last_o),
    .room_o      (room_o)
  );

  function automatic int clamp_half(int len);
    if (len < 2 || (len % 2) == 1) return 1;
    return len / 2;
  endfunction

  task automatic run(input int n, input int len, input string tag);
    phase_len_i = LEN_W'(len);
    for (int i = 0; i < n; i++) begin
      logic [7:0] w;
      logic       lst, rm;
      w   = 8'(1) << (m_mode * 2 + m_sub);
      lst = (m_cnt == m_half - 1);
      rm  = (m_half - m_cnt) >= 2;
      q_exp.push_back({w, 2'(m_mode), 1'(m_sub), lst, rm});
      q_tag.push_back(tag);
      if (lst) begin
        if (m_sub == 1 && m_mode == 3) m_half = clamp_half(int'(phase_len_i));
        if (m_sub == 1) m_mode = (m_mode + 1) % 4;
        m_sub = 1 - m_sub;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
      @(negedge clk_i);
    end
  endtask

  task automatic cmp(input string req, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] t=%0t actual=%0d expected=%0d", req, tag, $time, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    #1;
    if (q_exp.size() > 0) begin
      logic [12:0] e;
      string       t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      cmp("R4 wake", t, int'(wake_o), int'(e[12:5]));
      cmp("R2 mode", t, int'(mode_o), int'(e[4:3]));
      cmp("R3 sub",  t, int'(sub_o),  int'(e[2]));
      cmp("R8 last", t, int'(last_o), int'(e[1]));
      cmp("R9 room", t, int'(room_o), int'(e[0]));
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state seen before any edge after release
    checks++;
    if (!(mode_o == 2'd0 && sub_o == 1'b0 && wake_o == 8'h01)) begin
      errors++;
      $display("FAIL R1 reset state actual=%0d/%0d/%0d expected=0/0/1", mode_o, sub_o, wake_o);
    end
    rst_ni = 1'b1;
    run(90,  20, "R1 R5 default length");
    run(100, 6,  "R7 mid-rotation change");
    run(60,  7,  "R6 odd length");
    run(30,  0,  "R6 zero length");
    run(60,  4,  "R7 short length");
    run(60,  12, "R3 even length");
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule